// File: doc/BRIEF.md
# Byte-Port Command/Response Host Interface

This block is the device-side host port of a byte-wide command/response peripheral. The host sees two I/O offsets. Offset 0 is the data port. Offset 1 returns a status byte when read and takes a command byte when written. The host opens a request with a mode command and writes request bytes into a local buffer. It closes the request with an end command. The block then streams the buffered request to an internal responder over a valid/ready byte stream.

The responder answers over a second valid/ready stream. The block frames that answer for the host, using one status flag to mark the control bytes. The host first reads a start marker, then each payload byte, then an end marker. A cancel command returns the port to its ready state from any point. This also recovers the port after back-to-back commands.

The response payload conventionally carries its own total length as a big-endian 32-bit value in bytes 2 to 5. The block forwards it untouched.

Top module: `cmdport_host_if`

## Requirements
- R1: After reset the status byte reads 0x10 (only the ready-for-command bit set), `req_valid` is low and `rsp_ready` is low.
- R2: Status layout: bit0 output-full, bit1 input-full, bit2 frame flag, bit3 overflow, bit4 ready-for-command, bit5 ready-for-data, bits 7:6 zero. Reads of offset 1 return this byte. Writes to offset 1 are commands. Offset 0 carries data both ways.
- R3: Input-full is set in the cycle after any host write to either offset and clears one cycle later.
- R4: Command 0x01 in the ready state clears ready-for-command and sets ready-for-data. Command 0x01 in any other state is ignored. Any command code other than 0x01, 0x03 and 0x22 is ignored.
- R5: Data writes received while ready-for-data is set are stored in arrival order. Data writes at any other time are ignored and never reach the responder.
- R6: Command 0x03 while collecting clears ready-for-data. The block then streams the stored bytes in order on `req_data`, with `req_last` on the final byte. `req_data` holds steady while `req_ready` is low.
- R7: The request buffer holds DEPTH bytes (default 64). Further data bytes are dropped and set the overflow bit. The overflow bit stays set until a cancel.
- R8: Once the request has been delivered (at once if it was empty), the status shows output-full and the frame flag together. The data port then reads 0x01.
- R9: Each response byte is shown with output-full set and the frame flag clear. A read of offset 0 clears output-full. The next byte is accepted from the responder only after that read.
- R10: After the last payload byte is read, the status shows output-full with the frame flag and the data port reads 0x03. Reading that byte returns the port to ready (status 0x10 plus any overflow bit).
- R11: Command 0x22 at any time flushes the request and response state, clears output-full, the frame flag and overflow, and sets ready-for-command.
- R12: A read of offset 1 has no side effect. In particular it does not clear output-full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_addr | input | 1 | Offset: 0 data, 1 status/command |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte for the addressed offset (combinational) |
| req_valid | output | 1 | Request byte available to the responder |
| req_data | output | 8 | Request byte |
| req_last | output | 1 | Marks the final request byte |
| req_ready | input | 1 | Responder accepts the request byte |
| rsp_valid | input | 1 | Responder offers a response byte |
| rsp_data | input | 8 | Response byte |
| rsp_last | input | 1 | Marks the final response byte |
| rsp_ready | output | 1 | Block accepts the response byte |

## Verification
Every host write becomes visible in the status byte at the first clock edge after the strobe. Input-full and the command effects appear together, and input-full drops one edge later. The bench drives strobes on the falling edge and samples the status a half cycle after the capturing edge. It then samples again one full cycle later for the input-full release. Request bytes leave one per edge while `req_ready` is high, and the response stream can advance only after the host read that empties the output byte. For this reason the bench polls the status once per cycle for output-full instead of assuming a fixed latency. A queue-based monitor checks each request handshake, in order and with its last flag, on the falling edge before the edge that completes it.

// File: rtl/cmdport_host_if.sv
module cmdport_host_if #(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic       host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       req_valid,
  output logic [7:0] req_data,
  output logic       req_last,
  input  logic       req_ready,
  input  logic       rsp_valid,
  input  logic [7:0] rsp_data,
  input  logic       rsp_last,
  output logic       rsp_ready
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [7:0] OP_OPEN  = 8'h01;
  localparam logic [7:0] OP_CLOSE = 8'h03;
  localparam logic [7:0] OP_ABORT = 8'h22;

  typedef enum logic [2:0] {S_IDLE, S_COLLECT, S_SEND, S_HEAD, S_BODY, S_TAIL} phase_t;

  phase_t        ph;
  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] cnt, rptr;
  logic          obf, ibf, ovf, got_last;
  logic [7:0]    obyte;
  logic [7:0]    stat;

  wire wr_dat = host_wr && !host_addr;
  wire wr_cmd = host_wr && host_addr;
  wire rd_dat = host_rd && !host_addr;
  wire abort  = wr_cmd && host_wdata == OP_ABORT;
  wire f0     = ph == S_HEAD || ph == S_TAIL;
  wire room   = cnt < CW'(DEPTH);

  assign stat       = {2'b00, ph == S_COLLECT, ph == S_IDLE, ovf, f0, ibf, obf};
  assign host_rdata = host_addr ? stat :
                      ph == S_HEAD ? OP_OPEN :
                      ph == S_TAIL ? OP_CLOSE : obyte;
  assign req_valid  = ph == S_SEND;
  assign req_data   = mem[rptr[AW-1:0]];
  assign req_last   = rptr == cnt - 1'b1;
  assign rsp_ready  = ph == S_BODY && !obf && !got_last;

  always_ff @(posedge clk)
    if (ph == S_COLLECT && wr_dat && room)
      mem[cnt[AW-1:0]] <= host_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= S_IDLE;
      cnt <= '0;
      rptr <= '0;
      obf <= 1'b0;
      ibf <= 1'b0;
      ovf <= 1'b0;
      got_last <= 1'b0;
      obyte <= '0;
    end else begin
      ibf <= host_wr;
      if (abort) begin
        ph <= S_IDLE;
        cnt <= '0;
        rptr <= '0;
        obf <= 1'b0;
        ovf <= 1'b0;
        got_last <= 1'b0;
      end else begin
        unique case (ph)
          S_IDLE:
            if (wr_cmd && host_wdata == OP_OPEN) begin
              ph <= S_COLLECT;
              cnt <= '0;
            end
          S_COLLECT: begin
            if (wr_dat) begin
              if (room) cnt <= cnt + 1'b1;
              else ovf <= 1'b1;
            end
            if (wr_cmd && host_wdata == OP_CLOSE) begin
              rptr <= '0;
              if (cnt == '0) begin
                ph <= S_HEAD;
                obf <= 1'b1;
              end else ph <= S_SEND;
            end
          end
          S_SEND:
            if (req_ready) begin
              rptr <= rptr + 1'b1;
              if (req_last) begin
                ph <= S_HEAD;
                obf <= 1'b1;
              end
            end
          S_HEAD:
            if (rd_dat) begin
              ph <= S_BODY;
              obf <= 1'b0;
            end
          S_BODY:
            if (rsp_valid && rsp_ready) begin
              obyte <= rsp_data;
              obf <= 1'b1;
              got_last <= rsp_last;
            end else if (rd_dat && obf) begin
              if (got_last) begin
                ph <= S_TAIL;
                got_last <= 1'b0;
              end else obf <= 1'b0;
            end
          S_TAIL:
            if (rd_dat) begin
              ph <= S_IDLE;
              obf <= 1'b0;
            end
          default: ph <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmdport_host_if_chk.sv
module cmdport_host_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic       host_rd,
  input logic       host_addr,
  input logic [7:0] host_wdata,
  input logic       req_valid,
  input logic       req_ready,
  input logic [7:0] req_data,
  input logic [7:0] stat
);
  wire abort = host_wr && host_addr && host_wdata == 8'h22;

  a_r3_ibf_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> stat[1]);

  a_r3_ibf_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr |=> !stat[1]);

  a_r11_abort_ready: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> stat[4] && !stat[0] && !stat[2] && !stat[3] && !stat[5]);

  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !abort |=> req_valid && $stable(req_data));

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stat[3] && !abort |=> stat[3]);

  a_r12_status_read_keeps_obf: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_addr && !host_wr && stat[0] |=> stat[0]);

  a_r8_frame_needs_obf: assert property (@(posedge clk) disable iff (!rst_n)
    stat[2] |-> stat[0]);

  a_r2_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stat[4], stat[5], stat[2]}));
endmodule

bind cmdport_host_if cmdport_host_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .host_wdata(host_wdata), .req_valid(req_valid),
  .req_ready(req_ready), .req_data(req_data), .stat(stat)
);

// File: tb/cmdport_host_if_test.sv
module cmdport_host_if_test;
  localparam int DEPTH = 64;

  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0, host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic req_valid, req_last, req_ready = 0;
  logic [7:0] req_data;
  logic rsp_valid = 0, rsp_last = 0, rsp_ready;
  logic [7:0] rsp_data = 0;

  int total = 0, bad = 0;
  logic [8:0] exp_q[$];
  logic [7:0] rsp_q[$];
  logic [7:0] pl_q[$];
  bit hs = 0;
  bit collecting = 0;
  int ncoll = 0, rr_cnt = 0;

  always #2.5 clk = ~clk;

  cmdport_host_if #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .req_valid(req_valid), .req_data(req_data), .req_last(req_last),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_last(rsp_last), .rsp_ready(rsp_ready));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // request monitor: pops the scoreboard on each handshake
  always @(negedge clk) begin
    rr_cnt++;
    req_ready = (rr_cnt % 3) != 0;
    if (rst_n && req_valid && req_ready) begin
      if (exp_q.size() == 0) chk("R5 unexpected request byte", {req_last, req_data}, 9'h1ff);
      else chk("R6 request order/last", {req_last, req_data}, exp_q.pop_front());
    end
  end

  // responder
  always @(negedge clk) begin
    if (hs && rsp_q.size() > 0) void'(rsp_q.pop_front());
    rsp_valid = rsp_q.size() > 0;
    rsp_data  = rsp_valid ? rsp_q[0] : 8'h00;
    rsp_last  = rsp_q.size() == 1;
    hs = rsp_valid && rsp_ready;
  end

  task automatic host_write(logic a, logic [7:0] d);
    @(negedge clk);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic host_read(logic a, output logic [7:0] v);
    @(negedge clk);
    host_rd = 1; host_addr = a;
    #0.5 v = host_rdata;
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic peek(output logic [7:0] v);
    host_addr = 1;
    #0.5 v = host_rdata;
  endtask

  task automatic wait_obf();
    logic [7:0] v;
    do begin
      @(negedge clk);
      peek(v);
    end while (!v[0]);
  endtask

  task automatic cmd(logic [7:0] c);
    host_write(1, c);
    if (c == 8'h22) begin collecting = 0; ncoll = 0; end
    else if (c == 8'h01 && !collecting) begin collecting = 1; ncoll = 0; end
    else if (c == 8'h03 && collecting) begin
      collecting = 0;
      if (exp_q.size() > 0) exp_q[exp_q.size()-1][8] = 1'b1;
    end
  endtask

  task automatic send_byte(logic [7:0] b);
    if (collecting && ncoll < DEPTH) exp_q.push_back({1'b0, b});
    if (collecting) ncoll++;
    host_write(0, b);
  endtask

  task automatic frame_check(logic [7:0] base);
    logic [7:0] v;
    foreach (pl_q[i]) rsp_q.push_back(pl_q[i]);
    wait_obf();
    peek(v); chk("R8 head status", v, 8'h05 | base);
    host_read(1, v); chk("R12 status via read", v, 8'h05 | base);
    peek(v); chk("R12 obf kept after status read", v, 8'h05 | base);
    host_read(0, v); chk("R8 start marker", v, 8'h01);
    foreach (pl_q[i]) begin
      wait_obf();
      peek(v); chk("R9 payload status", v, 8'h01 | base);
      host_read(0, v); chk("R9 payload byte", v, pl_q[i]);
    end
    wait_obf();
    peek(v); chk("R10 tail status", v, 8'h05 | base);
    host_read(0, v); chk("R10 end marker", v, 8'h03);
    peek(v); chk("R10 back to ready", v, 8'h10 | base);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    peek(v); chk("R1 reset status", v, 8'h10);
    chk("R1 reset req_valid", req_valid, 0);
    chk("R1 reset rsp_ready", rsp_ready, 0);
    rst_n = 1;
    @(negedge clk);

    // R5: data while idle is ignored
    send_byte(8'hEE);
    peek(v); chk("R3 ibf after data write", v, 8'h12);
    @(negedge clk);
    peek(v); chk("R3 ibf released", v, 8'h10);

    cmd(8'h22);
    peek(v); chk("R2 status after cancel write", v, 8'h12);
    cmd(8'h01);
    peek(v); chk("R4 open with ibf", v, 8'h22);
    @(negedge clk);
    peek(v); chk("R4 ready-for-data", v, 8'h20);
    cmd(8'h01);
    cmd(8'h5A);
    @(negedge clk);
    peek(v); chk("R4 repeat open and unknown code ignored", v, 8'h20);

    // typical request with length field in the reply
    for (int i = 0; i < 10; i++) send_byte(8'h30 + 8'(i));
    cmd(8'h03);
    @(negedge clk);
    peek(v); chk("R6 ready-for-data cleared", v[5], 0);
    pl_q = '{8'h00, 8'hC4, 8'h00, 8'h00, 8'h00, 8'h09, 8'h11, 8'h22, 8'h33};
    frame_check(8'h00);
    chk("R6 all request bytes delivered", exp_q.size(), 0);

    // empty request goes straight to the head marker
    cmd(8'h01);
    cmd(8'h03);
    pl_q = '{8'hAB};
    frame_check(8'h00);

    // overflow
    cmd(8'h01);
    for (int i = 0; i < DEPTH + 3; i++) send_byte(8'(i * 7 + 1));
    @(negedge clk);
    peek(v); chk("R7 overflow bit", v, 8'h28);
    cmd(8'h03);
    pl_q = '{8'h5C, 8'h5D};
    frame_check(8'h08);
    chk("R7 only DEPTH bytes delivered", exp_q.size(), 0);
    cmd(8'h22);
    @(negedge clk);
    peek(v); chk("R11 cancel clears overflow", v, 8'h10);

    // cancel in the middle of a response
    cmd(8'h01);
    send_byte(8'hA1); send_byte(8'hA2);
    cmd(8'h03);
    rsp_q.push_back(8'h55); rsp_q.push_back(8'h66);
    wait_obf();
    host_read(0, v); chk("R8 start marker before cancel", v, 8'h01);
    wait_obf();
    peek(v); chk("R9 first byte shown", v, 8'h01);
    rsp_q.delete();
    cmd(8'h22);
    @(negedge clk);
    peek(v); chk("R11 cancel mid-response", v, 8'h10);
    chk("R11 rsp_ready low after cancel", rsp_ready, 0);

    // flushed state: new request carries only its own byte
    cmd(8'h01);
    send_byte(8'h77);
    cmd(8'h03);
    pl_q = '{8'h99, 8'h98};
    frame_check(8'h00);
    chk("R5 no stale request bytes", exp_q.size(), 0);

    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule